// File: doc/BRIEF.md
# Tag-Forwarding Operand Broadcast with Reservation Queues

This block sits between instruction dispatch and two functional units: an adder and a multiplier. Each unit has a short queue of waiting operations. An operand that is not yet computed is dispatched as a 4-bit producer tag instead of a value. Producers are memory load returns and unit results. Each producer announces its tag on a shared broadcast bus and sends the data on the bus in the following cycle. Every queue slot watches the bus and takes the value directly when the tag matches. An operation issues to its unit once both operands hold values.

Only one producer can broadcast per cycle. A fixed-priority arbiter chooses the producer: the multiplier first, then the adder, then loads. A producer that loses holds its result and stalls until it wins. A consumer can arm itself on the tag cycle and latch the data on the next cycle. A tag is free for reuse as soon as its broadcast ends. Both units are modelled as fixed-latency pipes: 1 cycle for the adder and 2 cycles for the multiplier.

Top module: `cdb_forward_top`

## Requirements
- R1: During and after reset, no tag or data broadcast is signalled, `ld_grant_o` is 0 and `disp_ready_o` is 1.
- R2: Each broadcast shows its tag with `cdb_tag_valid_o` in one cycle. In the next cycle it shows `cdb_data_valid_o`, with `cdb_data_tag_o` equal to that tag.
- R3: A queued operand waiting on tag T takes the data of the next broadcast of T. One broadcast fills every operand that waits on T, in both queues.
- R4: An operand dispatched in the tag cycle of a broadcast of its tag takes that broadcast's data. So does an operand dispatched in the data cycle of that broadcast.
- R5: A broadcast whose tag no queued operand waits on changes no queue entry. An operand dispatched after a broadcast of T ends waits for a later broadcast of T, so the tag can be reused.
- R6: An entry issues only when both operands hold values. Within one unit, the oldest ready entry issues first, whatever slot it occupies.
- R7: Unit 0 (`disp_unit_i`=0) returns a+b mod 2^16, and unit 1 returns the low 16 bits of a*b. With no contention and both operands given, the data cycle comes LAT+1 clock edges after the dispatch edge (adder LAT=1, multiplier LAT=2).
- R8: If several producers are ready in the same cycle, the multiplier result is broadcast first, then the adder result, then the load. A losing unit keeps its result and broadcasts it later unchanged. A load is broadcast in a cycle where `ld_grant_o`=1, and the requester holds it until then.
- R9: A dependency chain of loads, a multiply and adds gives the same results as executing the operations in order.
- R10: `disp_ready_o` is 0 while the queue selected by `disp_unit_i` holds 3 entries, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch an operation this cycle |
| disp_unit_i | input | 1 | Target unit: 0 adder, 1 multiplier |
| disp_dst_i | input | 4 | Tag the result will be broadcast with |
| disp_a_pend_i | input | 1 | Operand A not yet available, wait on tag |
| disp_a_tag_i | input | 4 | Producer tag of operand A |
| disp_a_val_i | input | 16 | Value of operand A when not pending |
| disp_b_pend_i | input | 1 | Operand B not yet available, wait on tag |
| disp_b_tag_i | input | 4 | Producer tag of operand B |
| disp_b_val_i | input | 16 | Value of operand B when not pending |
| disp_ready_o | output | 1 | Selected unit's queue has a free slot |
| ld_valid_i | input | 1 | A load return requests the bus |
| ld_tag_i | input | 4 | Tag of the load return |
| ld_data_i | input | 16 | Data of the load return |
| ld_grant_o | output | 1 | Load wins the bus this cycle |
| cdb_tag_valid_o | output | 1 | Tag cycle of a broadcast |
| cdb_tag_o | output | 4 | Tag being announced |
| cdb_data_valid_o | output | 1 | Data cycle of a broadcast |
| cdb_data_tag_o | output | 4 | Tag of the data being sent |
| cdb_data_o | output | 16 | Broadcast data |

## Verification
Operand pairs that wrap past 16 bits are swept through both units, which separates the adder from the multiplier and checks the exact latency of each. Load–multiply–add chains with fresh values on every round show whether forwarded results reach all consumers, and whether reused tags pick up new data rather than stale data. Targeted sequences test the remaining cases. Dispatch is placed exactly in the tag cycle and exactly in the data cycle, to test capture on the edge. A stray tag is broadcast, to confirm it has no effect. An older entry is placed in a higher-numbered slot, which separates oldest-first issue from slot order. Three producers are made to collide in one cycle, which exposes the arbiter's priority and the stall hold.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int TAG_W   = 4;
  localparam int DATA_W  = 16;
  localparam int N_UNITS = 2;
  localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
  localparam int N_SRC   = N_UNITS + 1;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic {FU_ADD = 1'b0, FU_MUL = 1'b1} fu_kind_e;

  typedef struct packed {
    logic  pend;
    tag_t  tag;
    data_t val;
  } opnd_t;

  typedef struct packed {
    tag_t  dst;
    opnd_t a;
    opnd_t b;
  } disp_t;
endpackage

// File: rtl/cdb_arbiter.sv
module cdb_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  assign gnt_o = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/cdb_fu_pipe.sv
module cdb_fu_pipe
  import cdb_pkg::*;
#(
  parameter fu_kind_e KIND = FU_ADD,
  parameter int       LAT  = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  input  tag_t  in_dst_i,
  input  data_t in_a_i,
  input  data_t in_b_i,
  input  logic  grant_i,
  output logic  accept_o,
  output logic  out_valid_o,
  output tag_t  out_tag_o,
  output data_t out_data_o
);
  logic  [LAT-1:0] v_q;
  tag_t  [LAT-1:0] t_q;
  data_t [LAT-1:0] d_q;
  data_t           res;

  generate
    if (KIND == FU_MUL) begin : g_mul
      logic [2*DATA_W-1:0] prod;
      assign prod = {{DATA_W{1'b0}}, in_a_i} * {{DATA_W{1'b0}}, in_b_i};
      assign res  = prod[DATA_W-1:0];
    end else begin : g_add
      assign res = in_a_i + in_b_i;
    end
  endgenerate

  // whole pipe stalls while its result waits for the bus
  assign accept_o = !v_q[LAT-1] || grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      t_q <= '0;
      d_q <= '0;
    end else if (accept_o) begin
      v_q[0] <= in_valid_i;
      t_q[0] <= in_dst_i;
      d_q[0] <= res;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        t_q[k] <= t_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_tag_o   = t_q[LAT-1];
  assign out_data_o  = d_q[LAT-1];
endmodule

// File: rtl/cdb_rs_queue.sv
module cdb_rs_queue
  import cdb_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  alloc_i,
  input  disp_t alloc_op_i,
  input  logic  tp_valid_i,
  input  tag_t  tp_tag_i,
  input  logic  dp_valid_i,
  input  tag_t  dp_tag_i,
  input  data_t dp_data_i,
  input  logic  issue_en_i,
  output logic  full_o,
  output logic  iss_valid_o,
  output tag_t  iss_dst_o,
  output data_t iss_a_o,
  output data_t iss_b_o
);
  typedef struct packed {
    logic  rdy;
    logic  arm;
    tag_t  tag;
    data_t val;
  } slot_t;

  logic  [DEPTH-1:0]            vld_q;
  tag_t  [DEPTH-1:0]            dst_q;
  slot_t [DEPTH-1:0]            a_q, b_q;
  logic  [DEPTH-1:0][DEPTH-1:0] older_q;  // [i][j]: j is older than i
  logic  [DEPTH-1:0]            rdy, sel, alloc_oh;
  logic                         alloc_fire;

  function automatic slot_t fresh(opnd_t o);
    slot_t s;
    s.tag = o.tag;
    s.val = o.val;
    s.rdy = !o.pend;
    s.arm = 1'b0;
    if (o.pend) begin
      if (dp_valid_i && dp_tag_i == o.tag) begin
        s.rdy = 1'b1;
        s.val = dp_data_i;
      end else begin
        s.arm = tp_valid_i && tp_tag_i == o.tag;
      end
    end
    return s;
  endfunction

  function automatic slot_t snoop(slot_t s);
    slot_t r = s;
    if (!s.rdy) begin
      if (s.arm && dp_valid_i) begin
        r.rdy = 1'b1;
        r.val = dp_data_i;
        r.arm = 1'b0;
      end else begin
        r.arm = tp_valid_i && tp_tag_i == s.tag;
      end
    end
    return r;
  endfunction

  always_comb begin
    alloc_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_oh = DEPTH'(1) << i;
    end
  end

  assign full_o     = &vld_q;
  assign alloc_fire = alloc_i && !full_o;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) rdy[i] = vld_q[i] && a_q[i].rdy && b_q[i].rdy;
    for (int i = 0; i < DEPTH; i++) sel[i] = rdy[i] && !(|(older_q[i] & rdy));
  end

  always_comb begin
    iss_valid_o = |sel;
    iss_dst_o   = '0;
    iss_a_o     = '0;
    iss_b_o     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        iss_dst_o = dst_q[i];
        iss_a_o   = a_q[i].val;
        iss_b_o   = b_q[i].val;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dst_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= snoop(a_q[i]);
        b_q[i] <= snoop(b_q[i]);
        if (issue_en_i && sel[i]) vld_q[i] <= 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
          if (alloc_fire && alloc_oh[j]) older_q[i][j] <= 1'b0;
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && alloc_oh[i]) begin
          vld_q[i]   <= 1'b1;
          dst_q[i]   <= alloc_op_i.dst;
          a_q[i]     <= fresh(alloc_op_i.a);
          b_q[i]     <= fresh(alloc_op_i.b);
          older_q[i] <= vld_q;
        end
      end
    end
  end
endmodule

// File: rtl/cdb_forward_top.sv
module cdb_forward_top
  import cdb_pkg::*;
#(
  parameter int Q_DEPTH = 3,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [UNIT_W-1:0] disp_unit_i,
  input  logic [TAG_W-1:0]  disp_dst_i,
  input  logic              disp_a_pend_i,
  input  logic [TAG_W-1:0]  disp_a_tag_i,
  input  logic [DATA_W-1:0] disp_a_val_i,
  input  logic              disp_b_pend_i,
  input  logic [TAG_W-1:0]  disp_b_tag_i,
  input  logic [DATA_W-1:0] disp_b_val_i,
  output logic              disp_ready_o,
  input  logic              ld_valid_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              ld_grant_o,
  output logic              cdb_tag_valid_o,
  output logic [TAG_W-1:0]  cdb_tag_o,
  output logic              cdb_data_valid_o,
  output logic [TAG_W-1:0]  cdb_data_tag_o,
  output logic [DATA_W-1:0] cdb_data_o
);
  disp_t                   disp_op;
  logic  [N_UNITS-1:0]     full;
  logic  [N_SRC-1:0]       req, gnt;
  tag_t  [N_SRC-1:0]       src_tag;
  data_t [N_SRC-1:0]       src_data;
  logic                    tp_valid;
  tag_t                    tp_tag;
  data_t                   tp_data;
  logic                    dp_valid_q;
  tag_t                    dp_tag_q;
  data_t                   dp_data_q;

  assign disp_op = '{dst: disp_dst_i,
                     a: '{pend: disp_a_pend_i, tag: disp_a_tag_i, val: disp_a_val_i},
                     b: '{pend: disp_b_pend_i, tag: disp_b_tag_i, val: disp_b_val_i}};

  // sources: higher unit index has higher priority, load last
  genvar u;
  generate
    for (u = 0; u < N_UNITS; u++) begin : g_unit
      logic  iss_v, acc, out_v;
      tag_t  iss_dst, out_tag;
      data_t iss_a, iss_b, out_data;

      cdb_rs_queue #(.DEPTH(Q_DEPTH)) i_queue (
        .clk_i, .rst_ni,
        .alloc_i    (disp_valid_i && disp_unit_i == UNIT_W'(u)),
        .alloc_op_i (disp_op),
        .tp_valid_i (tp_valid),
        .tp_tag_i   (tp_tag),
        .dp_valid_i (dp_valid_q),
        .dp_tag_i   (dp_tag_q),
        .dp_data_i  (dp_data_q),
        .issue_en_i (acc),
        .full_o     (full[u]),
        .iss_valid_o(iss_v),
        .iss_dst_o  (iss_dst),
        .iss_a_o    (iss_a),
        .iss_b_o    (iss_b)
      );

      cdb_fu_pipe #(
        .KIND (u == 0 ? FU_ADD : FU_MUL),
        .LAT  (u == 0 ? ADD_LAT : MUL_LAT)
      ) i_pipe (
        .clk_i, .rst_ni,
        .in_valid_i (iss_v),
        .in_dst_i   (iss_dst),
        .in_a_i     (iss_a),
        .in_b_i     (iss_b),
        .grant_i    (gnt[N_UNITS-1-u]),
        .accept_o   (acc),
        .out_valid_o(out_v),
        .out_tag_o  (out_tag),
        .out_data_o (out_data)
      );

      assign req[N_UNITS-1-u]      = out_v;
      assign src_tag[N_UNITS-1-u]  = out_tag;
      assign src_data[N_UNITS-1-u] = out_data;
    end
  endgenerate

  assign req[N_SRC-1]      = ld_valid_i;
  assign src_tag[N_SRC-1]  = ld_tag_i;
  assign src_data[N_SRC-1] = ld_data_i;

  cdb_arbiter #(.N(N_SRC)) i_arb (.req_i(req), .gnt_o(gnt));

  always_comb begin
    tp_tag  = '0;
    tp_data = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (gnt[s]) begin
        tp_tag  = src_tag[s];
        tp_data = src_data[s];
      end
    end
  end
  assign tp_valid = |req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid_q <= 1'b0;
      dp_tag_q   <= '0;
      dp_data_q  <= '0;
    end else begin
      dp_valid_q <= tp_valid;
      dp_tag_q   <= tp_tag;
      dp_data_q  <= tp_data;
    end
  end

  assign disp_ready_o     = !full[disp_unit_i];
  assign ld_grant_o       = gnt[N_SRC-1];
  assign cdb_tag_valid_o  = tp_valid;
  assign cdb_tag_o        = tp_tag;
  assign cdb_data_valid_o = dp_valid_q;
  assign cdb_data_tag_o   = dp_tag_q;
  assign cdb_data_o       = dp_data_q;
endmodule

// File: rtl/cdb_forward_chk.sv
module cdb_forward_chk
  import cdb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ld_valid_i,
  input tag_t       ld_tag_i,
  input logic       ld_grant_o,
  input logic       cdb_tag_valid_o,
  input tag_t       cdb_tag_o,
  input logic       cdb_data_valid_o,
  input tag_t       cdb_data_tag_o
);
  a_r2_tag_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_tag_valid_o |=> cdb_data_valid_o && cdb_data_tag_o == $past(cdb_tag_o));

  a_r2_data_after_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_data_valid_o |-> $past(cdb_tag_valid_o));

  a_r8_load_grant_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_grant_o |-> ld_valid_i && cdb_tag_valid_o && cdb_tag_o == ld_tag_i);

  a_r8_load_loses_to_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && !ld_grant_o |-> cdb_tag_valid_o);
endmodule

bind cdb_forward_top cdb_forward_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ld_valid_i      (ld_valid_i),
  .ld_tag_i        (ld_tag_i),
  .ld_grant_o      (ld_grant_o),
  .cdb_tag_valid_o (cdb_tag_valid_o),
  .cdb_tag_o       (cdb_tag_o),
  .cdb_data_valid_o(cdb_data_valid_o),
  .cdb_data_tag_o  (cdb_data_tag_o)
);

// File: tb/test_cdb_forward_top.sv
`timescale 1ns/1ps
module test_cdb_forward_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [0:0]  disp_unit = '0;
  logic [3:0]  disp_dst = '0, disp_a_tag = '0, disp_b_tag = '0;
  logic        disp_a_pend = 1'b0, disp_b_pend = 1'b0;
  logic [15:0] disp_a_val = '0, disp_b_val = '0;
  logic        disp_ready;
  logic        ld_valid = 1'b0;
  logic [3:0]  ld_tag = '0;
  logic [15:0] ld_data = '0;
  logic        ld_grant;
  logic        tag_v, data_v;
  logic [3:0]  tag_o, data_tag;
  logic [15:0] data_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  int unsigned bcnt[16] = '{default: 0};
  logic [15:0] bres[16] = '{default: '0};
  int bcyc[16] = '{default: 0};

  always #2 clk = ~clk;

  cdb_forward_top i_cdb_forward_top (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_unit_i(disp_unit), .disp_dst_i(disp_dst),
    .disp_a_pend_i(disp_a_pend), .disp_a_tag_i(disp_a_tag), .disp_a_val_i(disp_a_val),
    .disp_b_pend_i(disp_b_pend), .disp_b_tag_i(disp_b_tag), .disp_b_val_i(disp_b_val),
    .disp_ready_o(disp_ready),
    .ld_valid_i(ld_valid), .ld_tag_i(ld_tag), .ld_data_i(ld_data), .ld_grant_o(ld_grant),
    .cdb_tag_valid_o(tag_v), .cdb_tag_o(tag_o),
    .cdb_data_valid_o(data_v), .cdb_data_tag_o(data_tag), .cdb_data_o(data_o)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && data_v) begin
      bcnt[data_tag] = bcnt[data_tag] + 1;
      bres[data_tag] = data_o;
      bcyc[data_tag] = cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic set_disp(input bit u, input logic [3:0] dst,
                          input bit ap, input logic [3:0] at, input logic [15:0] av,
                          input bit bp, input logic [3:0] bt, input logic [15:0] bv);
    disp_valid = 1'b1; disp_unit = u; disp_dst = dst;
    disp_a_pend = ap; disp_a_tag = at; disp_a_val = av;
    disp_b_pend = bp; disp_b_tag = bt; disp_b_val = bv;
  endtask

  task automatic disp(input bit u, input logic [3:0] dst,
                      input bit ap, input logic [3:0] at, input logic [15:0] av,
                      input bit bp, input logic [3:0] bt, input logic [15:0] bv);
    @(negedge clk);
    set_disp(u, dst, ap, at, av, bp, bt, bv);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic load(input logic [3:0] t, input logic [15:0] d);
    bit g;
    @(negedge clk);
    ld_valid = 1'b1; ld_tag = t; ld_data = d;
    forever begin
      #1 g = ld_grant;
      @(negedge clk);
      if (g) break;
    end
    ld_valid = 1'b0;
  endtask

  task automatic wait_bc(input logic [3:0] t, input int unsigned base);
    for (int n = 0; n < 50 && bcnt[t] == base; n++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int unsigned b1, b2, b3, b4, b5;
    logic [15:0] x, y, c;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 tag_valid", tag_v, 0);
    chk("R1 data_valid", data_v, 0);
    chk("R1 ld_grant", ld_grant, 0);
    chk("R1 disp_ready", disp_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {tag_v, data_v, ld_grant}, 0);

    // R7: operand sweep through both units, latency and result
    for (int u = 0; u < 2; u++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] a, b, e;
        logic [31:0] p;
        logic [3:0] dst;
        int n;
        a = 16'((i * 16'h3A5F) ^ 16'hF00F);
        b = 16'(i * 16'h1111 + 16'hFFF0);
        p = {16'h0, a} * {16'h0, b};
        e = (u == 0) ? 16'(a + b) : p[15:0];
        dst = 4'(i + u * 8);
        @(negedge clk);
        set_disp(u[0], dst, 0, 0, a, 0, 0, b);
        @(negedge clk);
        disp_valid = 1'b0;
        n = 0;
        while (!(data_v && data_tag == dst) && n < 20) begin
          @(negedge clk);
          n++;
        end
        chk($sformatf("R7 latency unit%0d", u), n, (u == 0) ? 2 : 3);
        chk($sformatf("R7 result unit%0d", u), data_o, e);
      end
    end

    // R9 R3: load -> multiply -> two adds, against in-order execution
    for (int it = 0; it < 6; it++) begin
      logic [31:0] p;
      x = 16'(it * 16'h2F1 + 3);
      y = 16'(16'hFFFF - it * 16'h0777);
      c = 16'(it * 16'h1357);
      p = {16'h0, x} * {16'h0, y};
      b3 = bcnt[3]; b4 = bcnt[4]; b5 = bcnt[5];
      disp(1, 3, 1, 1, 0, 1, 2, 0);
      disp(0, 4, 1, 3, 0, 0, 0, c);
      disp(0, 5, 1, 3, 0, 1, 1, 0);
      load(1, x);
      load(2, y);
      wait_bc(4, b4);
      wait_bc(5, b5);
      chk("R9 mul", bres[3], p[15:0]);
      chk("R9 add imm", bres[4], 16'(p[15:0] + c));
      chk("R3 add two waiters", bres[5], 16'(p[15:0] + x));
      chk("R3 one broadcast each", bcnt[3] - b3, 1);
    end

    // R4: dispatch during tag cycle, then during data cycle
    b1 = bcnt[7];
    @(negedge clk);
    ld_valid = 1'b1; ld_tag = 6; ld_data = 16'h1200;
    set_disp(0, 7, 1, 6, 0, 0, 0, 16'h0005);
    #1 chk("R4 load wins idle bus", ld_grant, 1);
    @(negedge clk);
    ld_valid = 1'b0; disp_valid = 1'b0;
    wait_bc(7, b1);
    chk("R4 tag-cycle dispatch", bres[7], 16'h1205);
    b2 = bcnt[8];
    @(negedge clk);
    ld_valid = 1'b1; ld_tag = 6; ld_data = 16'h0340;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R2 data cycle", {data_v, data_tag}, {1'b1, 4'd6});
    set_disp(0, 8, 1, 6, 0, 0, 0, 16'h0009);
    @(negedge clk);
    disp_valid = 1'b0;
    wait_bc(8, b2);
    chk("R4 data-cycle dispatch", bres[8], 16'h0349);

    // R5: stray tag ignored, old broadcast of tag 6 not reused
    b1 = bcnt[7];
    disp(0, 7, 1, 6, 0, 0, 0, 16'h0001);
    load(9, 16'hAAAA);
    repeat (6) @(negedge clk);
    chk("R5 no wake on other tag", bcnt[7], b1);
    load(6, 16'h0100);
    wait_bc(7, b1);
    chk("R5 reused tag new data", bres[7], 16'h0101);

    // R10 R3: fill the adder queue, one broadcast wakes all three
    b1 = bcnt[10]; b2 = bcnt[11]; b3 = bcnt[12];
    disp(0, 10, 1, 13, 0, 0, 0, 16'd1);
    disp(0, 11, 1, 13, 0, 0, 0, 16'd2);
    disp(0, 12, 1, 13, 0, 0, 0, 16'd3);
    @(negedge clk);
    disp_unit = 0;
    #1 chk("R10 adder full", disp_ready, 0);
    disp_unit = 1;
    #1 chk("R10 multiplier free", disp_ready, 1);
    load(13, 16'h7FF0);
    wait_bc(12, b3);
    repeat (2) @(negedge clk);
    chk("R3 waiter 0", bres[10], 16'h7FF1);
    chk("R3 waiter 1", bres[11], 16'h7FF2);
    chk("R3 waiter 2", bres[12], 16'h7FF3);
    chk("R3 single result each", (bcnt[10] - b1) + (bcnt[11] - b2) + (bcnt[12] - b3), 3);
    @(negedge clk);
    disp_unit = 0;
    #1 chk("R10 adder drained", disp_ready, 1);

    // R6: older entry in higher slot issues first
    b1 = bcnt[1]; b2 = bcnt[2]; b3 = bcnt[3];
    disp(0, 1, 1, 11, 0, 0, 0, 16'd0);
    disp(0, 2, 1, 10, 0, 0, 0, 16'd1);
    load(11, 16'd5);
    wait_bc(1, b1);
    chk("R6 first", bres[1], 16'd5);
    disp(0, 3, 1, 10, 0, 0, 0, 16'd2);
    load(10, 16'd50);
    wait_bc(3, b3);
    chk("R6 older result", bres[2], 16'd51);
    chk("R6 younger result", bres[3], 16'd52);
    chk("R6 oldest first", bcyc[2] < bcyc[3], 1);

    // R8: mul, add and load collide in one tag cycle
    b1 = bcnt[14]; b2 = bcnt[15];
    @(negedge clk);
    set_disp(1, 14, 0, 0, 16'd3, 0, 0, 16'd4);
    @(negedge clk);
    set_disp(0, 15, 0, 0, 16'd1, 0, 0, 16'd2);
    @(negedge clk);
    disp_valid = 1'b0;
    @(negedge clk);
    ld_valid = 1'b1; ld_tag = 9; ld_data = 16'd77;
    #1 chk("R8 mul first", {tag_v, tag_o, ld_grant}, {1'b1, 4'd14, 1'b0});
    @(negedge clk);
    #1 chk("R8 add second", {tag_v, tag_o, ld_grant}, {1'b1, 4'd15, 1'b0});
    chk("R2 mul data follows", {data_v, data_tag}, {1'b1, 4'd14});
    @(negedge clk);
    #1 chk("R8 load last", {tag_v, tag_o, ld_grant}, {1'b1, 4'd9, 1'b1});
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R8 load data", {data_v, data_tag, data_o}, {1'b1, 4'd9, 16'd77});
    chk("R8 mul value", bres[14], 16'd12);
    chk("R8 stalled add value", bres[15], 16'd3);
    chk("R8 one broadcast each", (bcnt[14] - b1) + (bcnt[15] - b2), 2);

    report();
  end
endmodule